// File: doc/BRIEF.md
# Lockstep Mismatch Rollback Controller

This block watches a pair of pipelines that run the same program in lockstep and compares what both copies produce at the execute stage on every cycle. When the two copies disagree, it recovers without any stored checkpoint. It drives the same controls a mispredicted branch would drive on the instruction just ahead of the failing one. It flushes the fetch, decode and execute stages, stops the failing instruction from writing register or memory state, and steers fetch back to the failing instruction's address so that it runs again from the start of the pipeline.

The controller also keeps a saturating count of recoveries. It notices when the same instruction keeps failing on retry: after a configurable number of back-to-back failures at one address, it raises a sticky persistent-fault flag that a redundancy manager can use to bring in a third copy. All outputs are registered. The recovery controls form a single-cycle pulse that appears in the cycle after the mismatching comparison.

Top module: `lockstep_rollback_ctl`

## Requirements
- R1: While reset is high, and in the cycle after it, every output is zero.
- R2: No recovery is started when neither lane's execute stage is valid, or when both lanes are valid with equal PC and equal result.
- R3: A recovery starts when the lanes disagree at the execute stage: only one lane valid, different PCs, or different results. In the cycle after that comparison, `redirect_valid_o` is high for exactly one cycle.
- R4: `redirect_pc_o` takes the lane-A execute PC of the mismatching cycle, or lane B's PC when lane A is invalid. It holds that value until the next recovery.
- R5: `flush_o` is 3'b111 during the recovery pulse and 3'b000 otherwise. Bit 0 flushes fetch, bit 1 flushes decode and bit 2 flushes execute. `wb_kill_o` is high in exactly the same cycles as `redirect_valid_o`.
- R6: The execute-stage comparison is ignored in the cycle in which the recovery pulse is high, because that stage is being flushed.
- R7: `recovery_count_o` rises by one per recovery and stays at 2^CNT_W-1 once it gets there.
- R8: `persist_fault_o` rises after RETRY_LIMIT consecutive recoveries at one PC and stays high until reset.
- R9: The consecutive-failure run restarts when that PC passes execute with matching lanes, or when a recovery happens at a different PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_ex_valid | input | 1 | Lane A execute stage holds an instruction |
| a_ex_pc | input | PC_W | Lane A execute-stage PC |
| a_ex_result | input | DATA_W | Lane A execute-stage result |
| b_ex_valid | input | 1 | Lane B execute stage holds an instruction |
| b_ex_pc | input | PC_W | Lane B execute-stage PC |
| b_ex_result | input | DATA_W | Lane B execute-stage result |
| flush_o | output | 3 | Stage flush: bit0 fetch, bit1 decode, bit2 execute |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Fetch redirect address (failing instruction) |
| wb_kill_o | output | 1 | Suppress the state update of the failing instruction |
| recovery_count_o | output | CNT_W | Saturating count of recoveries |
| persist_fault_o | output | 1 | Sticky repeated-failure flag |

## Verification
The main comparison is swept over every pair of 4-bit results with both lanes valid. Each pair uses its own PC, so the sweep tells equal data apart from unequal data and also drives the saturating counter to its ceiling. Separate patterns use lanes with the same result but different PCs, and lanes where only A or only B is valid. These show that disagreement in control alone still triggers recovery, and show which lane's PC is chosen for the redirect. A mismatch placed directly after another shows the blanking of the flushed stage. Runs of failures at one address, broken by a clean pass or by a failure elsewhere, separate the persistent-fault threshold from ordinary retries.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int NUM_FLUSH = 3;
  localparam int FL_FETCH  = 0;
  localparam int FL_DECODE = 1;
  localparam int FL_EXEC   = 2;
  typedef logic [NUM_FLUSH-1:0] flush_vec_t;
  localparam flush_vec_t FLUSH_ALL  = '1;
  localparam flush_vec_t FLUSH_NONE = '0;
endpackage

// File: rtl/lsr_compare.sv
module lsr_compare #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter bit CMP_PC = 1'b1
) (
  input  logic              a_valid,
  input  logic [PC_W-1:0]   a_pc,
  input  logic [DATA_W-1:0] a_res,
  input  logic              b_valid,
  input  logic [PC_W-1:0]   b_pc,
  input  logic [DATA_W-1:0] b_res,
  output logic              differ,
  output logic              agree,
  output logic [PC_W-1:0]   fail_pc
);
  logic pc_ne;
  logic res_ne;
  logic any_v;

  generate
    if (CMP_PC) begin : g_pc_cmp
      assign pc_ne = (a_pc != b_pc);
    end else begin : g_no_pc_cmp
      assign pc_ne = 1'b0;
    end
  endgenerate

  assign res_ne = (a_res != b_res);
  assign any_v  = a_valid | b_valid;

  always_comb begin
    differ = 1'b0;
    if (any_v) begin
      if (a_valid != b_valid) differ = 1'b1;
      else if (pc_ne || res_ne) differ = 1'b1;
    end
  end

  assign agree   = a_valid & b_valid & ~pc_ne & ~res_ne;
  assign fail_pc = a_valid ? a_pc : b_pc;
endmodule

// File: rtl/lsr_satcnt.sv
module lsr_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/lsr_streak.sv
module lsr_streak #(
  parameter int PC_W        = 32,
  parameter int RETRY_LIMIT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fail_ev,
  input  logic            pass_ev,
  input  logic [PC_W-1:0] ev_pc,
  output logic            persist
);
  localparam int ST_W = $clog2(RETRY_LIMIT + 1);
  localparam logic [ST_W-1:0] LIMIT = ST_W'(RETRY_LIMIT);

  logic [PC_W-1:0] last_pc;
  logic            tracking;
  logic [ST_W-1:0] run_len;
  logic [ST_W-1:0] next_len;
  logic            same_pc;

  assign same_pc = tracking && (ev_pc == last_pc);

  always_comb begin
    if (same_pc) next_len = (run_len == LIMIT) ? LIMIT : run_len + 1'b1;
    else         next_len = ST_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pc  <= '0;
      tracking <= 1'b0;
      run_len  <= '0;
      persist  <= 1'b0;
    end else if (fail_ev) begin
      last_pc  <= ev_pc;
      tracking <= 1'b1;
      run_len  <= next_len;
      if (next_len >= LIMIT) persist <= 1'b1;
    end else if (pass_ev && same_pc) begin
      tracking <= 1'b0;
      run_len  <= '0;
    end
  end
endmodule

// File: rtl/lockstep_rollback_ctl.sv
module lockstep_rollback_ctl
  import lsr_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int RETRY_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_ex_valid,
  input  logic [PC_W-1:0]   a_ex_pc,
  input  logic [DATA_W-1:0] a_ex_result,
  input  logic              b_ex_valid,
  input  logic [PC_W-1:0]   b_ex_pc,
  input  logic [DATA_W-1:0] b_ex_result,
  output logic [2:0]        flush_o,
  output logic              redirect_valid_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic              wb_kill_o,
  output logic [CNT_W-1:0]  recovery_count_o,
  output logic              persist_fault_o
);
  logic            differ;
  logic            agree;
  logic [PC_W-1:0] fail_pc;
  logic            start_rec;
  logic            pass_ok;
  flush_vec_t      flush_q;
  logic            redir_q;
  logic            kill_q;
  logic [PC_W-1:0] redir_pc_q;

  lsr_compare #(.PC_W(PC_W), .DATA_W(DATA_W), .CMP_PC(1'b1)) u_cmp (
    .a_valid (a_ex_valid),
    .a_pc    (a_ex_pc),
    .a_res   (a_ex_result),
    .b_valid (b_ex_valid),
    .b_pc    (b_ex_pc),
    .b_res   (b_ex_result),
    .differ  (differ),
    .agree   (agree),
    .fail_pc (fail_pc)
  );

  // the stage being flushed this cycle carries a younger instruction: ignore it
  assign start_rec = differ & ~redir_q;
  assign pass_ok   = agree & ~redir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q    <= FLUSH_NONE;
      redir_q    <= 1'b0;
      kill_q     <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      flush_q <= start_rec ? FLUSH_ALL : FLUSH_NONE;
      redir_q <= start_rec;
      kill_q  <= start_rec;
      if (start_rec) redir_pc_q <= fail_pc;
    end
  end

  lsr_satcnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (start_rec),
    .count (recovery_count_o)
  );

  lsr_streak #(.PC_W(PC_W), .RETRY_LIMIT(RETRY_LIMIT)) u_streak (
    .clk     (clk),
    .rst     (rst),
    .fail_ev (start_rec),
    .pass_ev (pass_ok),
    .ev_pc   (fail_pc),
    .persist (persist_fault_o)
  );

  assign flush_o          = flush_q;
  assign redirect_valid_o = redir_q;
  assign wb_kill_o        = kill_q;
  assign redirect_pc_o    = redir_pc_q;
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             a_ex_valid,
  input logic             b_ex_valid,
  input logic [2:0]       flush_o,
  input logic             redirect_valid_o,
  input logic [PC_W-1:0]  redirect_pc_o,
  input logic             wb_kill_o,
  input logic [CNT_W-1:0] recovery_count_o,
  input logic             persist_fault_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!redirect_valid_o && recovery_count_o == '0 && !persist_fault_o && flush_o == 3'b000));

  // R2
  idle_no_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_ex_valid && !b_ex_valid) |=> !redirect_valid_o);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid_o |=> !redirect_valid_o);

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid_o |=> (redirect_valid_o || $stable(redirect_pc_o)));

  // R5
  kill_align_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_kill_o == redirect_valid_o) && (flush_o == {3{redirect_valid_o}}));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid_o && $past(recovery_count_o) != CMAX && !$past(rst))
      |-> recovery_count_o == $past(recovery_count_o) + 1'b1);

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid_o |=> (redirect_valid_o || $stable(recovery_count_o)));

  // R8
  persist_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    persist_fault_o |=> persist_fault_o);
endmodule

bind lockstep_rollback_ctl lsr_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_lsr_chk (
  .clk              (clk),
  .rst              (rst),
  .a_ex_valid       (a_ex_valid),
  .b_ex_valid       (b_ex_valid),
  .flush_o          (flush_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .wb_kill_o        (wb_kill_o),
  .recovery_count_o (recovery_count_o),
  .persist_fault_o  (persist_fault_o)
);

// File: tb/lockstep_rollback_ctl_bench.sv
module lockstep_rollback_ctl_bench;
  localparam int PC_W = 8, DATA_W = 8, CNT_W = 4, RETRY_LIMIT = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_v = 1'b0, b_v = 1'b0;
  logic [PC_W-1:0] a_pc = '0, b_pc = '0;
  logic [DATA_W-1:0] a_r = '0, b_r = '0;
  logic [2:0] flush_o;
  logic redirect_valid_o, wb_kill_o, persist_fault_o;
  logic [PC_W-1:0] redirect_pc_o;
  logic [CNT_W-1:0] recovery_count_o;

  int total = 0, bad = 0;
  int exp_cnt = 0;
  int exp_pc = 0;

  always #2 clk = ~clk;

  lockstep_rollback_ctl #(.PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                          .RETRY_LIMIT(RETRY_LIMIT)) u_lockstep_rollback_ctl (
    .clk(clk), .rst(rst),
    .a_ex_valid(a_v), .a_ex_pc(a_pc), .a_ex_result(a_r),
    .b_ex_valid(b_v), .b_ex_pc(b_pc), .b_ex_result(b_r),
    .flush_o(flush_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .wb_kill_o(wb_kill_o),
    .recovery_count_o(recovery_count_o), .persist_fault_o(persist_fault_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample at following negedge
  task automatic step(input logic av, input int apc, input int ar,
                      input logic bv, input int bpc, input int br);
    a_v = av; a_pc = PC_W'(apc); a_r = DATA_W'(ar);
    b_v = bv; b_pc = PC_W'(bpc); b_r = DATA_W'(br);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bubble();
    step(1'b0, 0, 0, 1'b0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    a_v = 1'b0; b_v = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0;
    exp_pc = 0;
  endtask

  // checks the full recovery pulse after a step that should (or should not) recover
  task automatic expect_rec(input string req, input bit rec);
    if (rec) begin
      if (exp_cnt < CMAX) exp_cnt++;
    end
    check({req, " redirect_valid"}, int'(redirect_valid_o), int'(rec));
    check("R5 flush", int'(flush_o), rec ? 7 : 0);
    check("R5 wb_kill", int'(wb_kill_o), int'(rec));
    check("R4 redirect_pc", int'(redirect_pc_o), exp_pc);
    check("R7 count", int'(recovery_count_o), exp_cnt);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1 redirect_valid", int'(redirect_valid_o), 0);
    check("R1 flush", int'(flush_o), 0);
    check("R1 count", int'(recovery_count_o), 0);
    check("R1 persist", int'(persist_fault_o), 0);
    check("R1 redirect_pc", int'(redirect_pc_o), 0);

    // R2: both lanes bubbles with differing junk data
    step(1'b0, 5, 1, 1'b0, 9, 2);
    expect_rec("R2", 1'b0);

    // R2 R3 R7: sweep every 4-bit result pair, distinct PC per pair
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bit rec;
        rec = (a != b);
        if (rec) exp_pc = a * 16 + b;
        step(1'b1, a * 16 + b, a, 1'b1, a * 16 + b, b);
        expect_rec(rec ? "R3" : "R2", rec);
        bubble();
        expect_rec("R3 single pulse", 1'b0);
      end
    end
    check("R7 saturated", int'(recovery_count_o), CMAX);
    check("R8 no persist in sweep", int'(persist_fault_o), 0);

    do_reset();
    // R3: PC disagreement with equal results
    exp_pc = 8'h20;
    step(1'b1, 8'h20, 7, 1'b1, 8'h24, 7);
    expect_rec("R3 pc differ", 1'b1);
    bubble();
    // R3 R4: only lane A valid -> lane A PC
    exp_pc = 8'h30;
    step(1'b1, 8'h30, 1, 1'b0, 8'h99, 1);
    expect_rec("R3 only A", 1'b1);
    bubble();
    expect_rec("R4 hold", 1'b0);
    // R3 R4: only lane B valid -> lane B PC
    exp_pc = 8'h34;
    step(1'b0, 8'h77, 1, 1'b1, 8'h34, 1);
    expect_rec("R3 only B", 1'b1);
    // R6: mismatch presented during the pulse is ignored
    step(1'b1, 8'h50, 1, 1'b1, 8'h50, 2);
    expect_rec("R6 blanked", 1'b0);
    bubble();
    expect_rec("R6 after", 1'b0);

    do_reset();
    // R8: three consecutive failures at one PC
    for (int k = 1; k <= RETRY_LIMIT; k++) begin
      exp_pc = 8'h40;
      step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1);
      expect_rec("R8", 1'b1);
      check("R8 persist", int'(persist_fault_o), (k >= RETRY_LIMIT) ? 1 : 0);
      bubble();
    end
    bubble();
    check("R8 sticky", int'(persist_fault_o), 1);

    do_reset();
    // R9: run broken by a clean pass at the same PC
    exp_pc = 8'h40;
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    step(1'b1, 8'h40, 3, 1'b1, 8'h40, 3); bubble();
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    check("R9 pass resets run", int'(persist_fault_o), 0);
    // R9: run broken by a failure at another PC
    step(1'b1, 8'h44, 0, 1'b1, 8'h44, 1); bubble();
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    check("R9 other pc resets run", int'(persist_fault_o), 0);
    step(1'b1, 8'h40, 0, 1'b1, 8'h40, 1); bubble();
    check("R8 after rebuilt run", int'(persist_fault_o), 1);
    check("R7 count run", int'(recovery_count_o), 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule